// File: doc/BRIEF.md
# Phased Pseudo-Random Self-Test Sequencer

This block runs a full self-test of an external combinational circuit. On each test cycle it presents a pseudo-random pattern from an on-chip linear feedback generator. It takes the circuit's response back combinationally and folds that response into a multiple-input signature register. No stored pattern set is used. A single signature stands for the whole response stream.

The run is divided into a parameter-set number of phases, each of a fixed pattern count. A one-hot enable vector turns on only the group of control and observe test points that belongs to the active phase. The surrounding logic wires each bit of that vector to its own group of test points. After the last pattern of the last phase, the accumulated signature is compared once with a golden value supplied on an input port. The block then raises `done` with a pass/fail verdict.

The controller is a five-state machine. IDLE waits for `start`. SEED loads the generator seed and clears the compactor. RUN applies and captures one pattern per cycle. COMPARE checks the signature. DONE publishes `done` and returns to IDLE. The transitions are: IDLE→SEED on `start`; SEED→RUN always; RUN→RUN while patterns remain; RUN→COMPARE after the final pattern of the final phase; COMPARE→DONE always; DONE→IDLE always.

Top module: `lbist_phase_ctrl`

## Requirements
- R1: After reset `done`, `pass`, `tp_en` and `phase_idx` are all zero, and `cut_pattern` equals the SEED parameter (default 16'hACE1).
- R2: A `start` sampled high in IDLE moves to SEED for one cycle and then to RUN. The first pattern applied in RUN equals SEED.
- R3: In each RUN cycle the generator steps once as a right-shifting Galois register. The next value is (p >> 1) XOR (p[0] ? PAT_POLY : 0), with PAT_POLY defaulting to 16'hB400. Outside RUN the pattern holds.
- R4: The signature is cleared to zero in SEED. In each RUN cycle it becomes ((s >> 1) XOR (s[0] ? SIG_POLY : 0)) XOR `cut_response`, with SIG_POLY defaulting to 16'hB400.
- R5: Each phase lasts exactly PATS_PER_PHASE RUN cycles (default 256). `phase_idx` counts 0 to N_PHASES-1 (default 4) and is back at 0 after the run.
- R6: During RUN, `tp_en` has exactly bit `phase_idx` set. Outside RUN it is all zero.
- R7: After the last pattern of the last phase the block passes through COMPARE and DONE. `done` rises on the (N_PHASES*PATS_PER_PHASE+3)th clock edge after the edge that accepted `start`.
- R8: `pass` is 1 exactly when the final signature equals `golden_sig` as sampled in COMPARE.
- R9: Once high, `done` and `pass` hold until the next accepted `start`, which clears both on that edge.
- R10: `start` sampled in any state other than IDLE is ignored: the run continues with no disturbance to its patterns or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Requests a self-test run (acted on only in IDLE) |
| golden_sig | input | SIG_W | Expected good-circuit signature |
| cut_pattern | output | PAT_W | Pattern applied to the circuit under test |
| cut_response | input | SIG_W | Combinational response of the circuit under test |
| tp_en | output | N_PHASES | One-hot test-point group enable for the active phase |
| phase_idx | output | PH_W | Index of the active phase |
| done | output | 1 | Run finished; verdict valid |
| pass | output | 1 | Signature matched the golden value |

## Verification
The hardest situation to reach from the ports is a `start` pulse that lands inside a run. Such a pulse is most dangerous at a phase boundary or in COMPARE and DONE, where a careless design would restart or drop its verdict. The stimulus scatters random `start` pulses across whole runs. The bench predicts every pattern and test-point enable cycle by cycle and the exact edge on which `done` rises, so any disturbance shows up. The golden value is set either to the bench's predicted signature or to that value with one random bit flipped. This exercises both verdicts, and each verdict is held through idle cycles while the golden input changes.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SEED    = 3'd1,
        ST_RUN     = 3'd2,
        ST_COMPARE = 3'd3,
        ST_DONE    = 3'd4
    } lbist_state_e;

endpackage

// File: rtl/lbist_prpg.sv
module lbist_prpg #(
    parameter int           W    = 16,
    parameter logic [W-1:0] POLY = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    output logic [W-1:0] pattern
);

    logic [W-1:0] state_q;
    logic [W-1:0] state_nxt;

    // Galois form: one XOR level per stage, independent of width
    always_comb begin
        state_nxt = {1'b0, state_q[W-1:1]};
        if (state_q[0]) begin
            state_nxt = state_nxt ^ POLY;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (load) begin
            state_q <= SEED;
        end else if (step) begin
            state_q <= state_nxt;
        end
    end

    assign pattern = state_q;

endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
    parameter int           W    = 16,
    parameter logic [W-1:0] POLY = 16'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         capture,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] signature
);

    logic [W-1:0] sig_q;
    logic [W-1:0] shifted;

    always_comb begin
        shifted = {1'b0, sig_q[W-1:1]};
        if (sig_q[0]) begin
            shifted = shifted ^ POLY;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q <= '0;
        end else if (clear) begin
            sig_q <= '0;
        end else if (capture) begin
            sig_q <= shifted ^ data_in;
        end
    end

    assign signature = sig_q;

endmodule

// File: rtl/lbist_phase_cnt.sv
module lbist_phase_cnt #(
    parameter int N_PHASES       = 4,
    parameter int PATS_PER_PHASE = 256,
    parameter int PH_W           = (N_PHASES > 1) ? $clog2(N_PHASES) : 1,
    parameter int PC_W           = (PATS_PER_PHASE > 1) ? $clog2(PATS_PER_PHASE) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            step,
    output logic [PH_W-1:0] phase,
    output logic            run_end
);

    localparam logic [PC_W-1:0] LAST_PAT   = PC_W'(PATS_PER_PHASE - 1);
    localparam logic [PH_W-1:0] LAST_PHASE = PH_W'(N_PHASES - 1);

    logic [PC_W-1:0] pat_q;
    logic [PH_W-1:0] phase_q;
    logic            phase_end;

    assign phase_end = (pat_q == LAST_PAT);
    assign run_end   = phase_end && (phase_q == LAST_PHASE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pat_q   <= '0;
            phase_q <= '0;
        end else if (clear) begin
            pat_q   <= '0;
            phase_q <= '0;
        end else if (step) begin
            if (phase_end) begin
                pat_q   <= '0;
                phase_q <= run_end ? '0 : phase_q + 1'b1;
            end else begin
                pat_q   <= pat_q + 1'b1;
            end
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/lbist_phase_ctrl.sv
module lbist_phase_ctrl
    import lbist_pkg::*;
#(
    parameter int               PAT_W          = 16,
    parameter int               SIG_W          = 16,
    parameter int               N_PHASES       = 4,
    parameter int               PATS_PER_PHASE = 256,
    parameter logic [PAT_W-1:0] PAT_POLY       = 16'hB400,
    parameter logic [SIG_W-1:0] SIG_POLY       = 16'hB400,
    parameter logic [PAT_W-1:0] SEED           = 16'hACE1,
    parameter int               PH_W           = (N_PHASES > 1) ? $clog2(N_PHASES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [SIG_W-1:0]    golden_sig,
    output logic [PAT_W-1:0]    cut_pattern,
    input  logic [SIG_W-1:0]    cut_response,
    output logic [N_PHASES-1:0] tp_en,
    output logic [PH_W-1:0]     phase_idx,
    output logic                done,
    output logic                pass
);

    lbist_state_e     state_q;
    lbist_state_e     state_nxt;
    logic             in_seed;
    logic             in_run;
    logic             run_end;
    logic [PH_W-1:0]  phase;
    logic [SIG_W-1:0] signature;
    logic             done_q;
    logic             pass_q;

    assign in_seed = (state_q == ST_SEED);
    assign in_run  = (state_q == ST_RUN);

    lbist_prpg #(
        .W    (PAT_W),
        .POLY (PAT_POLY),
        .SEED (SEED)
    ) u_prpg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (in_seed),
        .step    (in_run),
        .pattern (cut_pattern)
    );

    lbist_misr #(
        .W    (SIG_W),
        .POLY (SIG_POLY)
    ) u_misr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (in_seed),
        .capture   (in_run),
        .data_in   (cut_response),
        .signature (signature)
    );

    lbist_phase_cnt #(
        .N_PHASES       (N_PHASES),
        .PATS_PER_PHASE (PATS_PER_PHASE),
        .PH_W           (PH_W)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (in_seed),
        .step    (in_run),
        .phase   (phase),
        .run_end (run_end)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Next-state decode
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_nxt = ST_SEED;
            ST_SEED:    state_nxt = ST_RUN;
            ST_RUN:     if (run_end) state_nxt = ST_COMPARE;
            ST_COMPARE: state_nxt = ST_DONE;
            ST_DONE:    state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    // Registered verdict outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            pass_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        done_q <= 1'b0;
                        pass_q <= 1'b0;
                    end
                end
                ST_COMPARE: pass_q <= (signature == golden_sig);
                ST_DONE:    done_q <= 1'b1;
                default: ;
            endcase
        end
    end

    // Test-point group decode: one bit per phase
    for (genvar g = 0; g < N_PHASES; g++) begin : g_tp
        assign tp_en[g] = in_run && (phase == PH_W'(g));
    end

    assign phase_idx = phase;
    assign done      = done_q;
    assign pass      = pass_q;

endmodule

// File: rtl/lbist_phase_ctrl_chk.sv
module lbist_phase_ctrl_chk
    import lbist_pkg::*;
#(
    parameter int               PAT_W    = 16,
    parameter int               N_PHASES = 4,
    parameter int               PH_W     = 2,
    parameter logic [PAT_W-1:0] PAT_POLY = 16'hB400,
    parameter logic [PAT_W-1:0] SEED     = 16'hACE1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input lbist_state_e        state,
    input logic [PAT_W-1:0]    cut_pattern,
    input logic [N_PHASES-1:0] tp_en,
    input logic [PH_W-1:0]     phase_idx,
    input logic                done,
    input logic                pass
);

    logic [PAT_W-1:0] exp_next;
    always_comb begin
        exp_next = cut_pattern >> 1;
        if (cut_pattern[0]) exp_next = exp_next ^ PAT_POLY;
    end

    p_tp_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tp_en));

    p_tp_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |-> (tp_en == '0));

    p_seed_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEED) |=> (state == ST_RUN) && (cut_pattern == SEED));

    p_lfsr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> (cut_pattern == $past(exp_next)));

    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state != ST_IDLE) |=> (state != ST_SEED));

    p_finish_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMPARE) |=> (state == ST_DONE) ##1 done);

    p_verdict_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && state == ST_IDLE && !start) |=> (done && $stable(pass)));

    p_phase_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(phase_idx) < N_PHASES));

endmodule

bind lbist_phase_ctrl lbist_phase_ctrl_chk #(
    .PAT_W    (PAT_W),
    .N_PHASES (N_PHASES),
    .PH_W     (PH_W),
    .PAT_POLY (PAT_POLY),
    .SEED     (SEED)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .state       (state_q),
    .cut_pattern (cut_pattern),
    .tp_en       (tp_en),
    .phase_idx   (phase_idx),
    .done        (done),
    .pass        (pass)
);

// File: tb/lbist_phase_ctrl_bench.sv
module lbist_phase_ctrl_bench;

    localparam int          CLK_PERIOD = 10;
    localparam int          NPH   = 4;
    localparam int          PPP   = 256;
    localparam int          TOTAL = NPH * PPP;
    localparam logic [15:0] POLY  = 16'hB400;
    localparam logic [15:0] SEEDV = 16'hACE1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] golden_sig = '0;
    logic [15:0] cut_pattern;
    logic [15:0] cut_response;
    logic [3:0]  tp_en;
    logic [1:0]  phase_idx;
    logic        done;
    logic        pass;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lbist_phase_ctrl #(
        .PAT_W(16), .SIG_W(16), .N_PHASES(NPH), .PATS_PER_PHASE(PPP),
        .PAT_POLY(POLY), .SIG_POLY(POLY), .SEED(SEEDV)
    ) u_lbist_phase_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .golden_sig(golden_sig),
        .cut_pattern(cut_pattern), .cut_response(cut_response),
        .tp_en(tp_en), .phase_idx(phase_idx), .done(done), .pass(pass)
    );

    // Circuit under test model: byte swap, with test points folding in low bits
    function automatic logic [15:0] cut_model(logic [15:0] p, logic [3:0] tp);
        return {p[7:0], p[15:8]} ^ {12'b0, tp & p[3:0]};
    endfunction

    function automatic logic [15:0] galois(logic [15:0] s);
        logic [15:0] n;
        n = s >> 1;
        if (s[0]) n = n ^ POLY;
        return n;
    endfunction

    function automatic logic [15:0] predict_sig();
        logic [15:0] p = SEEDV;
        logic [15:0] s = '0;
        for (int k = 0; k < TOTAL; k++) begin
            s = galois(s) ^ cut_model(p, 4'(1 << (k / PPP)));
            p = galois(p);
        end
        return s;
    endfunction

    assign cut_response = cut_model(cut_pattern, tp_en);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_once(logic [15:0] gold, logic exp_pass, bit noisy);
        logic [15:0] ep = SEEDV;
        logic [15:0] es = '0;
        logic [3:0]  etp;
        golden_sig = gold;
        @(negedge clk); start = 1'b1;
        @(posedge clk);            // edge that accepts start
        @(negedge clk); start = 1'b0;
        check("R9 done cleared", 32'(done), 0);
        check("R9 pass cleared", 32'(pass), 0);
        check("R2 seed cycle quiet", 32'(tp_en), 0);
        for (int k = 0; k < TOTAL; k++) begin
            @(posedge clk); @(negedge clk);
            etp = 4'(1 << (k / PPP));
            if (k == 0) check("R2 first pattern", 32'(cut_pattern), 32'(SEEDV));
            check("R3 pattern", 32'(cut_pattern), 32'(ep));
            check("R6 tp_en", 32'(tp_en), 32'(etp));
            check("R5 phase", 32'(phase_idx), 32'(k / PPP));
            if (done) check("R7 early done", 32'(done), 0);
            es = galois(es) ^ cut_model(ep, etp);
            ep = galois(ep);
            start = noisy ? ($urandom % 5 == 0) : 1'b0;   // R10 noise
        end
        @(posedge clk); @(negedge clk);                     // COMPARE
        start = noisy;
        check("R6 tp off in compare", 32'(tp_en), 0);
        check("R5 phase wraps", 32'(phase_idx), 0);
        check("R3 pattern holds", 32'(cut_pattern), 32'(ep));
        @(posedge clk); @(negedge clk);                     // DONE
        start = 1'b0;
        check("R7 done not yet", 32'(done), 0);
        @(posedge clk); @(negedge clk);
        check("R7 done edge", 32'(done), 1);
        check("R8 verdict", 32'(pass), 32'(exp_pass));
        check("R4 model agrees", 32'(es == gold), 32'(exp_pass));
        for (int i = 0; i < 3 + int'($urandom % 6); i++) begin
            golden_sig = 16'($urandom);
            @(posedge clk); @(negedge clk);
            check("R9 done hold", 32'(done), 1);
            check("R9 pass hold", 32'(pass), 32'(exp_pass));
            check("R3 idle pattern holds", 32'(cut_pattern), 32'(ep));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] good;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 done", 32'(done), 0);
        check("R1 pass", 32'(pass), 0);
        check("R1 tp_en", 32'(tp_en), 0);
        check("R1 phase", 32'(phase_idx), 0);
        check("R1 pattern", 32'(cut_pattern), 32'(SEEDV));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        good = predict_sig();
        run_once(good, 1'b1, 1'b0);                                   // R8 match
        run_once(good ^ 16'(1 << ($urandom % 16)), 1'b0, 1'b1);       // R8 one-bit miss, R10 noise
        run_once(good, 1'b1, 1'b1);                                   // R10 noise, verdict held
        run_once(16'($urandom) | 16'h1, (good == (16'($urandom) | 16'h1)) ? 1'b1 : 1'b0, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule